// File: doc/BRIEF.md
# Prioritized Trap Type Selector

This block collects synchronous trap requests raised by a processor pipeline into a pending set and, when the pipeline asks for a selection, picks the one trap to take. The winner is the pending request with the highest fixed priority. Each priority level carries its own 8-bit type code, and the code is produced in the same cycle as the select request. The lowest-priority level is the software trap instruction. Its code is built from a 7-bit trap number that the instruction supplies.

The select step also makes two special decisions. A reset trap overrides everything: it ignores the enable-traps bit, produces no type code and is only reported by a strobe. If a trap is pending while traps are disabled, the processor cannot take it. The block then enters a sticky error mode and drops its execute-mode indication until a system reset. Every select request empties the pending set, whatever the outcome.

Top module: `trap_pick`

## Requirements
- R1: After the active-low system reset `rst_n`, `pending` is all zero, `err_mode` is 0, `exec_mode` is 1, and `tt_valid` and `reset_taken` are 0.
- R2: In a cycle without `select`, the bits of `trap_raise` are ORed into `pending`, and the result is visible on the next cycle.
- R3: In a cycle with `select`, `pending` is replaced on the next cycle by that cycle's `trap_raise`. All earlier requests are dropped, whatever the outcome of the selection.
- R4: With `select` high, `reset_trap` low, `traps_en` high, `err_mode` low and `pending` non-zero, `tt_valid` is 1 in that same cycle. `tt_code` is the code of the lowest set index of `pending`. Index 0 has the highest priority. Index to code: 0→0x2B, 1→0x21, 2→0x20, 3→0x01, 4→0x03, 5→0x02, 6→0x04, 7→0x24, 8→0x25, 9→0x05, 10→0x06, 11→0x07, 12→0x08, 13→0x28, 14→0x29, 15→0x09, 16→0x0A, 17→0x2A.
- R5: When index 18 (software trap) is the winner, `tt_code` is `{1'b1, sw_num}`.
- R6: With `select` and `reset_trap` both high, `reset_taken` is 1 and `tt_valid` is 0 in that cycle. This holds whatever the values of `traps_en` and `pending`, and `err_mode` is not set by that select.
- R7: With `select` high, `reset_trap` low, `traps_en` low and `pending` non-zero, `tt_valid` is 0 in that cycle. From the next cycle on, `err_mode` is 1 and `exec_mode` is 0.
- R8: A `select` with `pending` all zero and `reset_trap` low gives `tt_valid` 0 and leaves `err_mode` at 0.
- R9: Once set, `err_mode` stays 1 until `rst_n` is asserted. While it is 1, `tt_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| trap_raise | input | 19 | New trap requests, one bit per priority level, index 0 highest |
| select | input | 1 | Request to select a trap this cycle |
| traps_en | input | 1 | Processor enable-traps bit |
| reset_trap | input | 1 | A reset trap is pending |
| sw_num | input | 7 | Trap number from the software trap instruction |
| tt_valid | output | 1 | Strobe: write `tt_code` to the type field |
| tt_code | output | 8 | Selected trap type code |
| reset_taken | output | 1 | Strobe: reset trap taken, type field untouched |
| err_mode | output | 1 | Sticky error mode |
| exec_mode | output | 1 | Execute mode, inverse of error mode |
| pending | output | 19 | Current pending trap set |

## Verification
The hardest case to reach is a select request that meets a pending set, disabled traps and a reset trap all at once. The reset must win, and error mode must stay clear. Only a run that first builds up pending bits over several raise cycles with traps disabled can show the difference between the reset bypass and the error path. The bench therefore stages that build-up before a select with the reset flag set. It then repeats the same pending set without the flag, so that the sticky error path and its suppression of later codes are seen. A reference model advances one clock at a time and compares every output in every cycle.

// File: rtl/trap_pick.sv
module trap_pick (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [18:0] trap_raise,
  input  logic        select,
  input  logic        traps_en,
  input  logic        reset_trap,
  input  logic [6:0]  sw_num,
  output logic        tt_valid,
  output logic [7:0]  tt_code,
  output logic        reset_taken,
  output logic        err_mode,
  output logic        exec_mode,
  output logic [18:0] pending
);
  localparam int NT = 19;
  localparam int SW = NT - 1;

  function automatic logic [7:0] level_code(input int idx);
    case (idx)
      0:  return 8'h2B;
      1:  return 8'h21;
      2:  return 8'h20;
      3:  return 8'h01;
      4:  return 8'h03;
      5:  return 8'h02;
      6:  return 8'h04;
      7:  return 8'h24;
      8:  return 8'h25;
      9:  return 8'h05;
      10: return 8'h06;
      11: return 8'h07;
      12: return 8'h08;
      13: return 8'h28;
      14: return 8'h29;
      15: return 8'h09;
      16: return 8'h0A;
      17: return 8'h2A;
      default: return 8'h00;
    endcase
  endfunction

  logic any_pend, take, fault;

  assign any_pend    = |pending;
  assign take        = select & ~reset_trap & ~err_mode & any_pend;
  assign tt_valid    = take & traps_en;
  assign fault       = take & ~traps_en;
  assign reset_taken = select & reset_trap;
  assign exec_mode   = ~err_mode;

  always_comb begin
    tt_code = 8'h00;
    for (int i = NT - 1; i >= 0; i--)
      if (pending[i])
        tt_code = (i == SW) ? {1'b1, sw_num} : level_code(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending  <= '0;
      err_mode <= 1'b0;
    end else begin
      pending <= select ? trap_raise : (pending | trap_raise);
      if (fault) err_mode <= 1'b1;
    end
  end

  a_r2_accumulate: assert property (@(posedge clk) disable iff (!rst_n)
    !select |=> pending == ($past(pending) | $past(trap_raise)));
  a_r3_clear_on_select: assert property (@(posedge clk) disable iff (!rst_n)
    select |=> pending == $past(trap_raise));
  a_r6_reset_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (select && reset_trap) |-> (!tt_valid && reset_taken));
  a_r7_error_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (select && !reset_trap && !traps_en && any_pend) |=> (err_mode && !exec_mode));
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_mode |=> err_mode);
  a_r9_no_code: assert property (@(posedge clk) disable iff (!rst_n)
    err_mode |-> !tt_valid);
  a_r4_strobe_needs_work: assert property (@(posedge clk) disable iff (!rst_n)
    tt_valid |-> (select && $countones(pending) > 0));
endmodule

// File: tb/trap_pick_bench.sv
module trap_pick_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [18:0] trap_raise = '0;
  logic        select = 1'b0;
  logic        traps_en = 1'b0;
  logic        reset_trap = 1'b0;
  logic [6:0]  sw_num = '0;
  logic        tt_valid, reset_taken, err_mode, exec_mode;
  logic [7:0]  tt_code;
  logic [18:0] pending;

  int checks = 0;
  int errors = 0;

  logic [18:0] m_pend;
  bit          m_err;
  byte unsigned codes [18];

  trap_pick u_trap_pick (
    .clk(clk), .rst_n(rst_n), .trap_raise(trap_raise), .select(select),
    .traps_en(traps_en), .reset_trap(reset_trap), .sw_num(sw_num),
    .tt_valid(tt_valid), .tt_code(tt_code), .reset_taken(reset_taken),
    .err_mode(err_mode), .exec_mode(exec_mode), .pending(pending)
  );

  always #10 clk = ~clk;

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog: run did not end, actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One cycle: drive inputs, compare outputs against the model, then advance it.
  task automatic step(input string tag, input logic [18:0] r, input bit s,
                      input bit en, input bit rt, input logic [6:0] n);
    bit       e_val, e_rst, take;
    logic [7:0] e_code;
    int       win;
    trap_raise = r; select = s; traps_en = en; reset_trap = rt; sw_num = n;
    #2;
    win = -1;
    for (int i = 0; i < 19; i++) if (m_pend[i] && win < 0) win = i;
    take   = s && !rt && !m_err && (win >= 0);
    e_val  = take && en;
    e_rst  = s && rt;
    e_code = (win == 18) ? {1'b1, n} : (win >= 0 ? codes[win] : 8'h00);
    check(tag, {tt_valid, reset_taken, err_mode, exec_mode, pending, (tt_valid ? tt_code : 8'h00), 8'h00},
               {e_val, e_rst, m_err, !m_err, m_pend, (e_val ? e_code : 8'h00), 8'h00});
    @(posedge clk);
    if (take && !en) m_err = 1'b1;
    m_pend = s ? r : (m_pend | r);
    @(negedge clk);
  endtask

  initial begin
    codes = '{8'h2B, 8'h21, 8'h20, 8'h01, 8'h03, 8'h02, 8'h04, 8'h24, 8'h25,
              8'h05, 8'h06, 8'h07, 8'h08, 8'h28, 8'h29, 8'h09, 8'h0A, 8'h2A};
    m_pend = '0; m_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step("R1 reset state", '0, 0, 0, 0, 0);

    for (int i = 0; i < 19; i++) begin
      step("R2 raise single", 19'(1) << i, 0, 1, 0, 7'h15);
      step("R4 R5 single code", '0, 1, 1, 0, 7'h15);
    end

    step("R2 raise a", 19'h40080, 0, 1, 0, 0);
    step("R2 raise b", 19'h00400, 0, 1, 0, 0);
    step("R4 multi priority", '0, 1, 1, 0, 0);
    step("R2 raise c", 19'h7FFFF, 0, 1, 0, 0);
    step("R4 all pending", 19'h00001, 1, 1, 0, 0);
    step("R3 raise during select kept", '0, 1, 1, 0, 0);
    step("R5 raise sw", 19'h40000, 0, 1, 0, 7'h7F);
    step("R5 sw max", '0, 1, 1, 0, 7'h7F);
    step("R5 raise sw", 19'h40000, 0, 1, 0, 7'h00);
    step("R5 sw zero", '0, 1, 1, 0, 7'h00);
    step("R8 empty select", '0, 1, 1, 0, 0);
    step("R8 empty disabled", '0, 1, 0, 0, 0);

    step("R2 stage disabled a", 19'h00020, 0, 0, 0, 0);
    step("R2 stage disabled b", 19'h01000, 0, 0, 0, 0);
    step("R6 reset bypass", '0, 1, 0, 1, 0);
    step("R6 after bypass", 19'h01020, 0, 0, 0, 0);
    step("R7 error entry", '0, 1, 0, 0, 0);
    step("R7 error visible", 19'h00004, 0, 1, 0, 0);
    step("R9 no code in error", '0, 1, 1, 0, 0);
    step("R9 sticky", 19'h00008, 0, 1, 0, 0);
    step("R6 reset in error", '0, 1, 1, 1, 0);
    step("R9 still sticky", '0, 0, 1, 0, 0);

    rst_n = 1'b0; m_pend = '0; m_err = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    step("R1 reset clears error", '0, 0, 1, 0, 0);
    step("R2 raise after reset", 19'h00200, 0, 1, 0, 0);
    step("R4 after reset", '0, 1, 1, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule